// File: doc/BRIEF.md
# Dual-Channel DAC Serial Command Interface

This block is the digital front end of a two-channel serial DAC. A host writes 16-bit command words over a write-only SPI-style port made of an active-low select, a serial clock and a data line. The block works in its own system clock domain. It passes all three serial pins through a synchronizer and finds serial clock edges by comparing successive samples. Once a full frame has arrived, the block decodes a 4-bit operation code and updates two register pairs. Each channel has a staging (input) register and a live (DAC) register.

The staging registers let the host prepare new values for both channels and then move them to the live registers together, so both outputs change on the same cycle. The operation code also sets a sleep/awake state. The live register values go out on two parallel buses. A single enable flag marks whether the analog outputs would be driven or left floating.

Top module: `dual_dac_cmd`

## Requirements
- R1: After reset, both output buses are zero and the enable flag is low (asleep). The staging registers are also zero.
- R2: A frame is 16 bits, sent most significant bit first and captured on rising serial clock edges while select is low. Bits 15:12 hold the operation code and bits 11:2 hold the 10-bit value. Bits 1:0 have no effect.
- R3: Code 4'b0001 writes the value into staging register A, and code 4'b0010 writes it into staging register B. Neither code changes the outputs or the enable flag.
- R4: Code 4'b1000 copies both staging registers into the live registers and sets the enable flag. The staging registers keep their values.
- R5: Code 4'b1001 writes staging A and then moves both channels to live (new A, old B). Code 4'b1010 does the same with the roles of A and B swapped. Both codes set the enable flag.
- R6: Code 4'b1111 writes the value into both staging registers and both live registers, and sets the enable flag.
- R7: Code 4'b1101 sets the enable flag. Code 4'b1110 clears it. Neither code changes any register.
- R8: Code 4'b0000 and the unassigned codes 4'b0011 to 4'b0111, 4'b1011 and 4'b1100 change nothing.
- R9: A command runs on the rising edge of select only if exactly 16 clock edges arrived while select was low. Shorter and longer frames are dropped.
- R10: Frame 16'h1100 stages the value 64 on channel A and leaves the outputs alone. A later frame 16'hA8FC stages 575 on channel B and moves both channels to live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Frame select, active low |
| spi_sck | input | 1 | Serial clock; data is taken on its rising edge |
| spi_mosi | input | 1 | Serial data in, most significant bit first |
| out_a | output | 10 | Live register of channel A |
| out_b | output | 10 | Live register of channel B |
| out_en | output | 1 | High when awake; low means the outputs float |

## Verification
On every cycle, the assertions check the following. The live registers move only on an update command. An update without a new load copies the staging value. The sleep and wake codes set the enable flag one cycle later. The unassigned codes leave all outputs stable. A command runs only after a bit count of exactly sixteen. Other behaviour is visible only through the bench scenarios: the exact value in each staging register, the routing of the new A and B values, padding bits that have no effect, and truncated or overlong frames. The bench covers every operation code from both the awake and the asleep state, and after each command it sends a transfer so that the staging registers show up on the outputs.

// File: rtl/dual_dac_cmd_pkg.sv
package dual_dac_cmd_pkg;
   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_NOP      = 4'h0,
      OP_STAGE_A  = 4'h1,
      OP_STAGE_B  = 4'h2,
      OP_XFER     = 4'h8,
      OP_STAGE_A_X= 4'h9,
      OP_STAGE_B_X= 4'hA,
      OP_WAKE     = 4'hD,
      OP_SLEEP    = 4'hE,
      OP_ALL      = 4'hF
   } dac_op_e;

   typedef struct packed {
      logic stage_a;
      logic stage_b;
      logic xfer;
      logic wake;
      logic sleep;
   } dac_ctl_t;
endpackage

// File: rtl/dual_dac_cmd_sync.sv
module dual_dac_cmd_sync #(
   parameter int W = 3,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/dual_dac_cmd_shift.sv
module dual_dac_cmd_shift #(
   parameter int FRAME_W = 16,
   localparam int CNT_W = $clog2(FRAME_W + 2)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_n_s,
   input  logic               sck_s,
   input  logic               mosi_s,
   output logic               frame_stb,
   output logic [FRAME_W-1:0] frame_word
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0] OVER = CNT_W'(FRAME_W + 1);

   logic               sck_d, cs_d;
   logic [CNT_W-1:0]   cnt;
   logic [FRAME_W-1:0] shreg;
   logic               sck_rise, cs_rise;

   assign sck_rise = sck_s & ~sck_d;
   assign cs_rise  = cs_n_s & ~cs_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d      <= 1'b0;
         cs_d       <= 1'b1;
         cnt        <= '0;
         shreg      <= '0;
         frame_stb  <= 1'b0;
         frame_word <= '0;
      end else begin
         sck_d     <= sck_s;
         cs_d      <= cs_n_s;
         frame_stb <= cs_rise && (cnt == FULL);
         if (cs_rise) frame_word <= shreg;
         if (cs_n_s) begin
            cnt <= '0;
         end else if (sck_rise) begin
            shreg <= {shreg[FRAME_W-2:0], mosi_s};
            if (cnt != OVER) cnt <= cnt + 1'b1;
         end
      end
   end

   p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= OVER);
   p_exact_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_stb |-> $past(cnt) == FULL);
endmodule

// File: rtl/dual_dac_cmd_chan.sv
module dual_dac_cmd_chan #(
   parameter int DATA_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stb,
   input  logic              ld,
   input  logic              upd,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dac_q
);
   logic [DATA_W-1:0] in_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_q  <= '0;
         dac_q <= '0;
      end else if (stb) begin
         if (ld) in_q <= din;
         if (upd) dac_q <= ld ? din : in_q;
      end
   end

   p_dac_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(stb && upd) |=> $stable(dac_q));
   p_xfer_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && upd && !ld) |=> dac_q == $past(in_q));
   p_stage_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(stb && ld) |=> $stable(in_q));
endmodule

// File: rtl/dual_dac_cmd.sv
module dual_dac_cmd
   import dual_dac_cmd_pkg::*;
#(
   parameter int DATA_W      = 10,
   parameter int PAD_W       = 2,
   parameter int SYNC_STAGES = 2,
   localparam int FRAME_W    = OP_W + DATA_W + PAD_W,
   localparam int NCH        = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_cs_n,
   input  logic              spi_sck,
   input  logic              spi_mosi,
   output logic [DATA_W-1:0] out_a,
   output logic [DATA_W-1:0] out_b,
   output logic              out_en
);
   if (DATA_W < 1)      begin : g_bad_data  $error("DATA_W must be at least 1"); end
   if (PAD_W < 0)       begin : g_bad_pad   $error("PAD_W must not be negative"); end
   if (SYNC_STAGES < 2) begin : g_bad_sync  $error("SYNC_STAGES must be at least 2"); end

   logic [2:0]         pins_s;
   logic               frame_stb;
   logic [FRAME_W-1:0] frame_word;
   logic [OP_W-1:0]    op;
   logic [DATA_W-1:0]  val;
   dac_ctl_t           ctl;
   logic [NCH-1:0]     ld_ch;
   logic [DATA_W-1:0]  dac_ch [NCH];
   logic               awake;

   dual_dac_cmd_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({spi_cs_n, spi_sck, spi_mosi}),
      .q    (pins_s)
   );

   dual_dac_cmd_shift #(.FRAME_W(FRAME_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n_s    (pins_s[2]),
      .sck_s     (pins_s[1]),
      .mosi_s    (pins_s[0]),
      .frame_stb (frame_stb),
      .frame_word(frame_word)
   );

   assign op  = frame_word[FRAME_W-1 -: OP_W];
   assign val = frame_word[FRAME_W-OP_W-1 -: DATA_W];

   always_comb begin
      ctl = '0;
      case (op)
         OP_STAGE_A:   ctl.stage_a = 1'b1;
         OP_STAGE_B:   ctl.stage_b = 1'b1;
         OP_XFER:      begin ctl.xfer = 1'b1; ctl.wake = 1'b1; end
         OP_STAGE_A_X: begin ctl.stage_a = 1'b1; ctl.xfer = 1'b1; ctl.wake = 1'b1; end
         OP_STAGE_B_X: begin ctl.stage_b = 1'b1; ctl.xfer = 1'b1; ctl.wake = 1'b1; end
         OP_ALL:       begin ctl.stage_a = 1'b1; ctl.stage_b = 1'b1;
                             ctl.xfer = 1'b1; ctl.wake = 1'b1; end
         OP_WAKE:      ctl.wake = 1'b1;
         OP_SLEEP:     ctl.sleep = 1'b1;
         default:      ctl = '0;
      endcase
   end

   assign ld_ch = {ctl.stage_b, ctl.stage_a};

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      dual_dac_cmd_chan #(.DATA_W(DATA_W)) u_chan (
         .clk  (clk),
         .rst_n(rst_n),
         .stb  (frame_stb),
         .ld   (ld_ch[c]),
         .upd  (ctl.xfer),
         .din  (val),
         .dac_q(dac_ch[c])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       awake <= 1'b0;
      else if (frame_stb && ctl.wake)   awake <= 1'b1;
      else if (frame_stb && ctl.sleep)  awake <= 1'b0;
   end

   assign out_a  = dac_ch[0];
   assign out_b  = dac_ch[1];
   assign out_en = awake;

   p_sleep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb && op == OP_SLEEP) |=> !out_en && $stable(out_a) && $stable(out_b));
   p_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb && (op == OP_WAKE || op == OP_XFER || op == OP_ALL)) |=> out_en);
   p_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb && !(op inside {OP_STAGE_A, OP_STAGE_B, OP_XFER, OP_STAGE_A_X,
                                 OP_STAGE_B_X, OP_WAKE, OP_SLEEP, OP_ALL}))
      |=> $stable(out_a) && $stable(out_b) && $stable(out_en));
   p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_stb |=> $stable(out_a) && $stable(out_b) && $stable(out_en));
endmodule

// File: tb/dual_dac_cmd_test.sv
module dual_dac_cmd_test;
   localparam int CLK_P = 10;
   localparam int HALF  = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       spi_cs_n = 1'b1;
   logic       spi_sck = 1'b0;
   logic       spi_mosi = 1'b0;
   logic [9:0] out_a, out_b;
   logic       out_en;

   int total = 0;
   int bad = 0;

   logic [9:0] m_ia = '0, m_ib = '0, m_da = '0, m_db = '0;
   logic       m_aw = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   dual_dac_cmd uut (
      .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
      .spi_mosi(spi_mosi), .out_a(out_a), .out_b(out_b), .out_en(out_en)
   );

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bits(input logic [31:0] w, input int n);
      spi_cs_n = 1'b0;
      wait_clk(HALF);
      for (int i = n - 1; i >= 0; i--) begin
         spi_mosi = w[i];
         wait_clk(HALF);
         spi_sck = 1'b1;
         wait_clk(HALF);
         spi_sck = 1'b0;
      end
      wait_clk(HALF);
      spi_cs_n = 1'b1;
      wait_clk(8);
   endtask

   function automatic logic [15:0] frame(input logic [3:0] c, input logic [9:0] d,
                                         input logic [1:0] pad);
      return {c, d, pad};
   endfunction

   task automatic model(input logic [3:0] c, input logic [9:0] d);
      case (c)
         4'h1: m_ia = d;
         4'h2: m_ib = d;
         4'h8: begin m_da = m_ia; m_db = m_ib; m_aw = 1'b1; end
         4'h9: begin m_ia = d; m_da = m_ia; m_db = m_ib; m_aw = 1'b1; end
         4'hA: begin m_ib = d; m_da = m_ia; m_db = m_ib; m_aw = 1'b1; end
         4'hF: begin m_ia = d; m_ib = d; m_da = d; m_db = d; m_aw = 1'b1; end
         4'hD: m_aw = 1'b1;
         4'hE: m_aw = 1'b0;
         default: ;
      endcase
   endtask

   function automatic string req_of(input logic [3:0] c);
      case (c)
         4'h1, 4'h2: return "R3";
         4'h8:       return "R4";
         4'h9, 4'hA: return "R5";
         4'hF:       return "R6";
         4'hD, 4'hE: return "R7";
         default:    return "R8";
      endcase
   endfunction

   task automatic check(input string req);
      logic [20:0] act, exp;
      act = {out_en, out_b, out_a};
      exp = {m_aw, m_db, m_da};
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: en/b/a actual=%0b/%0d/%0d expected=%0b/%0d/%0d",
                  req, act[20], act[19:10], act[9:0], exp[20], exp[19:10], exp[9:0]);
      end
   endtask

   task automatic cmd(input logic [3:0] c, input logic [9:0] d, input logic [1:0] pad,
                      input string req);
      send_bits({16'h0, frame(c, d, pad)}, 16);
      model(c, d);
      check(req);
   endtask

   initial begin
      wait_clk(3);
      rst_n = 1'b1;
      wait_clk(2);
      check("R1");
      // R1: staging registers start at zero, exposed by a transfer
      cmd(4'h8, 10'h0, 2'b00, "R1");

      // R10: worked example frames
      send_bits({16'h0, 16'h1100}, 16);
      m_ia = 10'd64;
      check("R10");
      send_bits({16'h0, 16'hA8FC}, 16);
      m_ib = 10'd575; m_da = m_ia; m_db = m_ib; m_aw = 1'b1;
      check("R10");

      // sweep every code from awake and asleep states
      for (int c = 0; c < 16; c++) begin
         for (int p = 0; p < 2; p++) begin
            logic [9:0] base, sa, sb, nv;
            base = p ? 10'h2AA : 10'h155;
            sa   = 10'h3C0 ^ 10'(c);
            sb   = 10'h01F + 10'(c * 3);
            nv   = 10'(c * 61 + p * 7 + 1);
            cmd(4'hF, base, 2'b00, "R6");
            cmd(4'h1, sa, 2'b01, "R3");
            cmd(4'h2, sb, 2'b10, "R3");
            if (p == 1) cmd(4'hE, 10'h3FF, 2'b11, "R7");
            // R2: padding bits set high for p==1 must not matter
            cmd(4'(c), nv, p ? 2'b11 : 2'b00, p ? "R2" : req_of(4'(c)));
            cmd(4'h8, 10'h0, 2'b00, req_of(4'(c)));
         end
      end

      // R9: short and long frames are dropped
      cmd(4'hE, 10'h0, 2'b00, "R7");
      send_bits({17'h0, frame(4'hF, 10'h123, 2'b00)[15:1]}, 15);
      check("R9");
      send_bits({15'h0, frame(4'hF, 10'h123, 2'b00), 1'b0}, 17);
      check("R9");
      send_bits({16'h0, frame(4'hF, 10'h123, 2'b00)}, 16);
      m_ia = 10'h123; m_ib = 10'h123; m_da = 10'h123; m_db = 10'h123; m_aw = 1'b1;
      check("R9");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule